// File: doc/BRIEF.md
# Peripheral Request Router and Channel Arbiter

This block sits between a set of peripheral request lines and a bank of DMA channels. Software writes one map register per request line, choosing whether the line is in use and which channel it drives. The block ORs the request levels of all enabled lines that point at the same channel into one routed request per channel. It then masks that request with each channel's running flag and, every cycle, picks one channel to own the shared data bus.

Channels fall into four priority groups. The group pattern has a period of 16 channels. A lower group always beats a higher one. Inside a group, a rotating pointer shares the bus fairly among the members. The block also collects the per-channel interrupt lines into one read-only summary word. The summary takes one register stage.

Top module: `req_router_arb`

## Requirements
- R1: A map register reads back with its enable flag at bit 7 and its channel number at bits 4:0. Every other bit reads as zero, whatever was written there.
- R2: The map register for request r (r < 64) is at byte offset 0x100 + 4·r. For r ≥ 64 it is at 0x1100 + 4·(r − 64). A write to any other offset, or to an offset that is not a multiple of 4, changes no map register. A read from an unmapped offset returns zero.
- R3: A request line whose enable flag is 0 has no effect on any routed channel request.
- R4: The routed request `ch_req_o[c]` is the OR of the levels of all enabled lines mapped to channel c. It follows the request inputs combinationally.
- R5: `grant_o` is zero or one-hot. A granted channel had both a routed request and `ch_run_i` high. When no channel is active, the grant is zero.
- R6: The group of channel c is (c mod 16) / 4. The grant goes to the lowest-numbered group that has an active channel.
- R7: Within a group, the pick rotates. Starting after the last channel granted from that group, it takes the next active member in ascending channel order and wraps around. After reset, the lowest active member is picked first.
- R8: `grant_o` is registered. It reflects the inputs present before the previous rising clock edge and lasts one cycle per arbitration.
- R9: The summary word at offset 0x0F0 holds bit i = `ch_irq_i[i]` as sampled at the previous rising edge. Writes to it have no effect.
- R10: After reset, all map registers, the grant and the summary are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | ADDR_W (16) | Register byte offset |
| cfg_wdata_i | input | DATA_W (32) | Register write data |
| cfg_rdata_o | output | DATA_W (32) | Register read data, combinational on the offset |
| per_req_i | input | NUM_REQ (128) | Peripheral request levels |
| ch_run_i | input | NUM_CH (32) | Channel running flags |
| ch_irq_i | input | NUM_CH (32) | Channel interrupt lines |
| ch_req_o | output | NUM_CH (32) | Routed request level per channel |
| grant_o | output | NUM_CH (32) | One-hot bus grant |

## Verification
Routed requests and map-register reads are combinational, so the bench samples them one time step after it changes the request lines or the offset. Map writes take effect at the rising edge that samples the strobe, and their readback is checked in the following half-cycle. The grant and the summary word are each one register deep. The bench applies new values at a falling edge, confirms that the old value is still present just before the next rising edge, and compares against the expected value at the falling edge after that. Expected grants come from a group-and-rotation model that the bench keeps in step one arbitration at a time.

// File: rtl/rra_pkg.sv
package rra_pkg;
  localparam logic [15:0] WIN_LO_BASE = 16'h0100;
  localparam logic [15:0] WIN_LO_END  = 16'h0200;
  localparam logic [15:0] WIN_HI_BASE = 16'h1100;
  localparam logic [15:0] WIN_HI_END  = 16'h1200;
  localparam logic [15:0] IRQ_SUM_OFS = 16'h00F0;
  localparam int unsigned WIN_SLOTS   = 64;
  localparam int unsigned MAP_EN_BIT  = 7;
  localparam int unsigned NUM_GRP     = 4;
  localparam int unsigned GRP_W       = 2;
  localparam int unsigned GRP_SPAN    = 4;
  localparam int unsigned GRP_PERIOD  = 16;

  function automatic int unsigned ch_grp(input int unsigned ch);
    return (ch % GRP_PERIOD) / GRP_SPAN;
  endfunction
endpackage

// File: rtl/req_map_bank.sv
module req_map_bank
  import rra_pkg::*;
#(
  parameter int unsigned NUM_REQ = 128,
  parameter int unsigned NUM_CH  = 32,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_CH-1:0] chan_req_o
);
  localparam int unsigned CH_W  = $clog2(NUM_CH);
  localparam int unsigned IDX_W = $clog2(NUM_REQ);

  logic [NUM_REQ-1:0] en_q;
  logic [CH_W-1:0]    ch_q [NUM_REQ];
  logic               in_lo, in_hi, aligned;
  logic [7:0]         sel_idx;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign in_lo   = aligned && (addr_i >= ADDR_W'(WIN_LO_BASE)) && (addr_i < ADDR_W'(WIN_LO_END));
  assign in_hi   = aligned && (addr_i >= ADDR_W'(WIN_HI_BASE)) && (addr_i < ADDR_W'(WIN_HI_END));
  assign sel_idx = {1'b0, in_hi, addr_i[7:2]};
  assign hit_o   = (in_lo || in_hi) && (sel_idx < 8'(NUM_REQ));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      for (int r = 0; r < NUM_REQ; r++) ch_q[r] <= '0;
    end else if (we_i && hit_o) begin
      for (int r = 0; r < NUM_REQ; r++) begin
        if (sel_idx == 8'(r)) begin
          en_q[r] <= wdata_i[MAP_EN_BIT];
          ch_q[r] <= wdata_i[CH_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_o) begin
      rdata_o[MAP_EN_BIT] = en_q[sel_idx[IDX_W-1:0]];
      rdata_o[CH_W-1:0]   = ch_q[sel_idx[IDX_W-1:0]];
    end
  end

  // several enabled lines on one channel OR together
  always_comb begin
    chan_req_o = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      if (en_q[r] && req_i[r]) chan_req_o[ch_q[r]] = 1'b1;
    end
  end

  // R3: no routed request without an enabled, asserted source line
  p_route_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|chan_req_o) |-> (|(req_i & en_q)));
endmodule

// File: rtl/grp_arbiter.sv
module grp_arbiter
  import rra_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] act_i,
  output logic [NUM_CH-1:0] grant_o
);
  localparam int unsigned CH_W = $clog2(NUM_CH);

  function automatic logic [NUM_CH-1:0] mk_mask(input int unsigned g);
    logic [NUM_CH-1:0] m;
    m = '0;
    for (int unsigned c = 0; c < NUM_CH; c++) m[c] = (ch_grp(c) == g);
    return m;
  endfunction

  localparam logic [NUM_CH-1:0] GRP0_MASK = mk_mask(0);

  logic [CH_W-1:0]   ptr_q   [NUM_GRP];
  logic              pick_vld[NUM_GRP];
  logic [CH_W-1:0]   pick_ch [NUM_GRP];
  logic              win_vld;
  logic [GRP_W-1:0]  win_grp;
  logic [NUM_CH-1:0] grant_d, grant_q;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    // rotate from the slot after the last winner of this group
    always_comb begin
      pick_vld[g] = 1'b0;
      pick_ch[g]  = '0;
      for (int unsigned k = 1; k <= NUM_CH; k++) begin
        automatic int unsigned c = (int'(ptr_q[g]) + k) % NUM_CH;
        if (!pick_vld[g] && (ch_grp(c) == g) && act_i[c]) begin
          pick_vld[g] = 1'b1;
          pick_ch[g]  = CH_W'(c);
        end
      end
    end
  end

  always_comb begin
    win_vld = 1'b0;
    win_grp = '0;
    for (int g = NUM_GRP - 1; g >= 0; g--) begin
      if (pick_vld[g]) begin
        win_vld = 1'b1;
        win_grp = GRP_W'(g);
      end
    end
    grant_d = '0;
    if (win_vld) grant_d[pick_ch[win_grp]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= '0;
      for (int g = 0; g < NUM_GRP; g++) ptr_q[g] <= CH_W'(NUM_CH - 1);
    end else begin
      grant_q <= grant_d;
      if (win_vld) ptr_q[win_grp] <= pick_ch[win_grp];
    end
  end

  assign grant_o = grant_q;

  p_grant_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_q));
  p_grant_needs_act_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((grant_q & ~$past(act_i)) == '0));
  p_grant_if_any_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|act_i) |=> (|grant_q));
  p_grp0_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(act_i & GRP0_MASK)) |=> (|(grant_q & GRP0_MASK)));
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] irq_i,
  output logic [NUM_CH-1:0] sum_o
);
  logic [NUM_CH-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= irq_i;
  end

  assign sum_o = sum_q;

  p_sum_lag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sum_q == $past(irq_i)));
endmodule

// File: rtl/req_router_arb.sv
module req_router_arb
  import rra_pkg::*;
#(
  parameter int unsigned NUM_REQ = 128,
  parameter int unsigned NUM_CH  = 32,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [DATA_W-1:0]  cfg_wdata_i,
  output logic [DATA_W-1:0]  cfg_rdata_o,
  input  logic [NUM_REQ-1:0] per_req_i,
  input  logic [NUM_CH-1:0]  ch_run_i,
  input  logic [NUM_CH-1:0]  ch_irq_i,
  output logic [NUM_CH-1:0]  ch_req_o,
  output logic [NUM_CH-1:0]  grant_o
);
  logic              map_hit;
  logic [DATA_W-1:0] map_rdata;
  logic [NUM_CH-1:0] sum_q;

  req_map_bank #(
    .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .hit_o     (map_hit),
    .rdata_o   (map_rdata),
    .req_i     (per_req_i),
    .chan_req_o(ch_req_o)
  );

  grp_arbiter #(.NUM_CH(NUM_CH)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (ch_req_o & ch_run_i),
    .grant_o(grant_o)
  );

  irq_summary #(.NUM_CH(NUM_CH)) u_sum (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .irq_i (ch_irq_i),
    .sum_o (sum_q)
  );

  always_comb begin
    if (map_hit)                               cfg_rdata_o = map_rdata;
    else if (cfg_addr_i == ADDR_W'(IRQ_SUM_OFS)) cfg_rdata_o = DATA_W'(sum_q);
    else                                       cfg_rdata_o = '0;
  end
endmodule

// File: tb/tb_req_router_arb.sv
module tb_req_router_arb;
  localparam int CLK_P = 20;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cfg_we_i = 1'b0;
  logic [15:0]  cfg_addr_i = '0;
  logic [31:0]  cfg_wdata_i = '0;
  logic [31:0]  cfg_rdata_o;
  logic [127:0] per_req_i = '0;
  logic [31:0]  ch_run_i = '0;
  logic [31:0]  ch_irq_i = '0;
  logic [31:0]  ch_req_o;
  logic [31:0]  grant_o;

  int n_chk = 0;
  int n_bad = 0;
  int unsigned mptr [4];

  always #(CLK_P/2) clk = ~clk;

  req_router_arb dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .per_req_i(per_req_i),
    .ch_run_i(ch_run_i), .ch_irq_i(ch_irq_i), .ch_req_o(ch_req_o), .grant_o(grant_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] map_addr(input int unsigned r);
    return (r < 64) ? 16'(16'h0100 + 4*r) : 16'(16'h1100 + 4*(r-64));
  endfunction

  function automatic int unsigned pat_ch(input int unsigned r);
    return (r*7 + 3) % 32;
  endfunction

  function automatic bit pat_en(input int unsigned r);
    return (r % 5) != 0;
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    cfg_addr_i = a;
    #1;
    d = cfg_rdata_o;
  endtask

  task automatic model_step(input logic [31:0] act, output logic [31:0] exp);
    exp = '0;
    for (int g = 0; g < 4; g++) begin
      for (int k = 1; k <= 32; k++) begin
        int unsigned c;
        c = (mptr[g] + k) % 32;
        if (exp == 0 && ((c % 16) / 4) == g && act[c]) begin
          exp = 32'h1 << c;
          mptr[g] = c;
        end
      end
    end
  endtask

  task automatic arb_step(input logic [31:0] req, input logic [31:0] run, input string tag);
    logic [31:0] exp;
    per_req_i = {96'b0, req};
    ch_run_i = run;
    model_step(req & run, exp);
    @(negedge clk);
    chk(grant_o == exp, tag, grant_o, exp);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [31:0] d, exp32, lfsr;
    logic [31:0] all_exp;
    for (int g = 0; g < 4; g++) mptr[g] = 31;

    // R10 reset state
    repeat (3) @(negedge clk);
    rd(16'h0100, d);  chk(d == 0, "R10 map0 after reset", d, 0);
    rd(16'h11FC, d);  chk(d == 0, "R10 map127 after reset", d, 0);
    rd(16'h00F0, d);  chk(d == 0, "R10 summary after reset", d, 0);
    chk(grant_o == 0, "R10 grant after reset", grant_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);

    // R1 R2 program every map register with junk in unused bits
    for (int r = 0; r < 128; r++)
      wr(map_addr(r), 32'hABCD_0060 | (32'(pat_en(r)) << 7) | 32'(pat_ch(r)));
    for (int r = 0; r < 128; r++) begin
      rd(map_addr(r), d);
      exp32 = (32'(pat_en(r)) << 7) | 32'(pat_ch(r));
      chk(d == exp32, "R1_R2 map readback", d, exp32);
    end

    // R2 offsets outside windows or misaligned
    wr(16'h0200, 32'h0000_009F);
    rd(16'h0200, d); chk(d == 0, "R2 unmapped read", d, 0);
    wr(16'h1000, 32'h0000_0081);
    wr(16'h0101, 32'h0000_0085);
    wr(16'h1200, 32'h0000_0085);
    rd(16'h0100, d); chk(d == 32'h03, "R2 stray writes left map0", d, 32'h03);
    rd(16'h1100, d); exp32 = (32'(pat_en(64)) << 7) | 32'(pat_ch(64));
    chk(d == exp32, "R2 stray writes left map64", d, exp32);

    // R3 R4 single-line routing sweep, run flags low so no grant
    for (int r = 0; r < 128; r++) begin
      per_req_i = 128'h1 << r;
      #1;
      exp32 = pat_en(r) ? (32'h1 << pat_ch(r)) : 32'h0;
      chk(ch_req_o == exp32, pat_en(r) ? "R4 routed line" : "R3 disabled line ignored", ch_req_o, exp32);
    end
    per_req_i = '0;
    per_req_i[1] = 1'b1; per_req_i[33] = 1'b1;
    #1; chk(ch_req_o == 32'h400, "R4 two lines one channel", ch_req_o, 32'h400);
    per_req_i = '1;
    all_exp = '0;
    for (int r = 0; r < 128; r++) if (pat_en(r)) all_exp[pat_ch(r)] = 1'b1;
    #1; chk(ch_req_o == all_exp, "R4 all lines", ch_req_o, all_exp);
    per_req_i = '0;
    @(negedge clk);
    chk(grant_o == 0, "R5 no grant while not running", grant_o, 0);

    // identity map for arbitration
    for (int r = 0; r < 128; r++) wr(map_addr(r), (r < 32) ? (32'h80 | 32'(r)) : 32'h0);

    // R5 none active / requests without run
    arb_step(32'h0, 32'hFFFF_FFFF, "R5 idle grant zero");
    arb_step(32'hFFFF_FFFF, 32'h0, "R5 run low masks");
    arb_step(32'h0000_00F0, 32'h0000_000F, "R5 disjoint req and run");

    // R6 group priority
    arb_step(32'h1000_0010, 32'hFFFF_FFFF, "R6 grp1 over grp3");
    chk(grant_o == 32'h10, "R6 ch4 wins", grant_o, 32'h10);
    arb_step(32'h0000_1200, 32'hFFFF_FFFF, "R6 grp2 over grp3");
    chk(grant_o == 32'h200, "R6 ch9 wins", grant_o, 32'h200);
    arb_step(32'h8010_0000, 32'hFFFF_FFFF, "R6 ch20 over ch31");
    arb_step(32'h0000_0000, 32'h0, "R5 drain");

    // R7 rotation within group 0
    for (int i = 0; i < 9; i++) begin
      int unsigned s;
      s = ((i % 8) < 4) ? (i % 8) : (12 + (i % 8));
      arb_step(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7 rotation model");
      chk(grant_o == (32'h1 << s), "R7 group0 order", grant_o, 32'h1 << s);
    end
    arb_step(32'h0, 32'h0, "R5 drain");

    // R8 latency: grant appears only after the edge
    per_req_i = {96'b0, 32'h20}; ch_run_i = 32'hFFFF_FFFF;
    model_step(32'h20, exp32);
    #1; chk(grant_o == 0, "R8 not before edge", grant_o, 0);
    @(negedge clk); chk(grant_o == 32'h20, "R8 after edge", grant_o, 32'h20);
    arb_step(32'h0, 32'hFFFF_FFFF, "R8 one cycle only");

    // R5 R6 R7 pseudo-random sweep against model
    lfsr = 32'h1357_9BDF;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rq, rn;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); rq = lfsr ^ (lfsr << 5); lfsr = rq;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); rn = lfsr ^ (lfsr << 5); lfsr = rn;
      arb_step(rq & (i[2] ? 32'hFFFF_FFFF : 32'hF0F0_F0F0), rn, "R7 random vs model");
    end
    arb_step(32'h0, 32'h0, "R5 drain");

    // R9 summary lag and read-only
    ch_irq_i = 32'hA5A5_0F3C;
    rd(16'h00F0, d); chk(d == 0, "R9 summary before edge", d, 0);
    @(negedge clk);
    rd(16'h00F0, d); chk(d == 32'hA5A5_0F3C, "R9 summary after edge", d, 32'hA5A5_0F3C);
    wr(16'h00F0, 32'h0);
    rd(16'h00F0, d); chk(d == 32'hA5A5_0F3C, "R9 write ignored", d, 32'hA5A5_0F3C);
    ch_irq_i = 32'h8000_0001;
    @(negedge clk);
    rd(16'h00F0, d); chk(d == 32'h8000_0001, "R9 second pattern", d, 32'h8000_0001);

    report();
    $finish;
  end
endmodule